// File: doc/BRIEF.md
# Output Data Register with Atomic Set/Clear

This block holds the output data word of a general-purpose port and gives a bus slave two ways to change it. A direct write loads the word, or a chosen byte of it. A separate write-only control word sets and clears any mix of output bits in one bus access. Software can therefore flip individual pins without a read-modify-write, and it does not need to mask interrupts while it does so.

The control word carries the set requests in its lower half and the clear requests in its upper half. A bit written as 0 in either half requests nothing. When both halves request the same position, the set request wins. The control word is one-shot and locks nothing, so direct writes keep working at all times. The output word is a register, and the read data is registered from the bus address.

Top module: `gpo_setclr_out`

## Requirements
- R1: While `rst` is high at a clock edge, `odr_o` and `rdata_o` become all zeros.
- R2: A write to word index 0 (the direct register) loads `odr_o[7:0]` from `wdata_i[7:0]` when `be_i[0]` is set, and `odr_o[15:8]` from `wdata_i[15:8]` when `be_i[1]` is set. `wdata_i[31:16]` and `be_i[3:2]` have no effect.
- R3: A write to word index 1 (the set/clear register) with `wdata_i[k]`=1 for k in 0..15 drives `odr_o[k]` to 1.
- R4: A write to word index 1 with `wdata_i[16+k]`=1 drives `odr_o[k]` to 0.
- R5: In a set/clear write, a position whose set bit and clear bit are both 0 keeps its previous value.
- R6: If one set/clear write requests both set and clear for the same position, that bit becomes 1.
- R7: The set/clear halves obey byte strobes. `be_i[0]` gates set bits 7:0, `be_i[1]` gates set bits 15:8, `be_i[2]` gates clear bits 7:0 and `be_i[3]` gates clear bits 15:8.
- R8: One clock edge after `addr_i` is presented, `rdata_o` holds `{16'b0, odr_o}` for index 0 and zero for every other index, including index 1.
- R9: A cycle with `we_i` low, or a write to any index other than 0 or 1, leaves `odr_o` unchanged.
- R10: A set/clear write locks nothing. A direct write that follows it fully determines the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Word index of the access |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes for the write |
| odr_o | output | 16 | Registered output data word |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions check on every cycle that set requests leave their bits at 1, that a clear request without a matching set leaves its bit at 0, and that untouched bits hold. They also check that idle cycles leave the word stable, that a full direct write lands exactly, and that reading the set/clear index returns zero. Only the bench scenarios can show that byte strobes gate each half correctly, that stray addresses and the upper half of a direct write are ignored, and that a long, mixed series of operations tracks an independent model, including direct writes that follow set/clear writes.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DIRECT = 2'd1,
    SEL_SETCLR = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpo_decode.sv
module gpo_decode #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int DIR_IDX = 0,
  parameter int SC_IDX  = 1,
  localparam int BUS_W  = 2 * DATA_W,
  localparam int NBYTE  = BUS_W / 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NBYTE-1:0]  be_i,
  output gpo_pkg::reg_sel_e sel_o,
  output logic [DATA_W-1:0] dir_mask_o,
  output logic [DATA_W-1:0] dir_data_o,
  output logic [DATA_W-1:0] set_o,
  output logic [DATA_W-1:0] clr_o
);
  logic [BUS_W-1:0] bit_en;

  // spread each byte strobe over its eight data bits
  for (genvar g = 0; g < BUS_W; g++) begin : g_bit_en
    assign bit_en[g] = be_i[g/8];
  end

  always_comb begin
    if (addr_i == ADDR_W'(DIR_IDX))     sel_o = gpo_pkg::SEL_DIRECT;
    else if (addr_i == ADDR_W'(SC_IDX)) sel_o = gpo_pkg::SEL_SETCLR;
    else                                sel_o = gpo_pkg::SEL_NONE;
  end

  always_comb begin
    dir_mask_o = '0;
    set_o      = '0;
    clr_o      = '0;
    if (we_i && sel_o == gpo_pkg::SEL_DIRECT)
      dir_mask_o = bit_en[DATA_W-1:0];
    if (we_i && sel_o == gpo_pkg::SEL_SETCLR) begin
      set_o = wdata_i[DATA_W-1:0]     & bit_en[DATA_W-1:0];
      clr_o = wdata_i[BUS_W-1:DATA_W] & bit_en[BUS_W-1:DATA_W];
    end
  end

  assign dir_data_o = wdata_i[DATA_W-1:0];
endmodule

// File: rtl/gpo_bit_cell.sv
module gpo_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic d_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // direct load and set/clear come from different addresses; set beats clear
  always_ff @(posedge clk) begin
    if (rst)         q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/gpo_readback.sv
module gpo_readback #(
  parameter int DATA_W = 16,
  localparam int BUS_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  gpo_pkg::reg_sel_e sel_i,
  input  logic [DATA_W-1:0] odr_i,
  output logic [BUS_W-1:0]  rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (sel_i == gpo_pkg::SEL_DIRECT) rdata_o <= {{DATA_W{1'b0}}, odr_i};
    else rdata_o <= '0;
  end
endmodule

// File: rtl/gpo_setclr_out.sv
module gpo_setclr_out #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int DIR_IDX = 0,
  parameter int SC_IDX  = 1,
  localparam int BUS_W  = 2 * DATA_W,
  localparam int NBYTE  = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NBYTE-1:0]  be_i,
  output logic [DATA_W-1:0] odr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  gpo_pkg::reg_sel_e sel;
  logic [DATA_W-1:0] dir_mask, dir_data, set_v, clr_v;

  gpo_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_IDX(DIR_IDX), .SC_IDX(SC_IDX)
  ) u_dec (
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .be_i(be_i),
    .sel_o(sel), .dir_mask_o(dir_mask), .dir_data_o(dir_data),
    .set_o(set_v), .clr_o(clr_v)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_cell
    gpo_bit_cell u_cell (
      .clk(clk), .rst(rst), .load_i(dir_mask[i]), .d_i(dir_data[i]),
      .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(odr_o[i])
    );
  end

  gpo_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .sel_i(sel), .odr_i(odr_o), .rdata_o(rdata_o)
  );

  p_rst_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> (odr_o == '0 && rdata_o == '0));

  p_set_lands_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((odr_o & $past(set_v)) == $past(set_v)));

  p_clr_lands_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((odr_o & $past(clr_v & ~set_v)) == '0));

  p_untouched_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |->
      (((odr_o ^ $past(odr_o)) & ~$past(set_v | clr_v | dir_mask)) == '0));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!we_i)) |-> $stable(odr_o));

  p_direct_full_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dir_mask) == {DATA_W{1'b1}}) |->
      (odr_o == $past(wdata_i[DATA_W-1:0])));

  p_sc_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sel) == gpo_pkg::SEL_SETCLR) |-> (rdata_o == '0));
endmodule

// File: tb/gpo_setclr_out_test.sv
module gpo_setclr_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [15:0] odr;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [15:0] model = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpo_setclr_out uut (
    .clk(clk), .rst(rst), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .be_i(be), .odr_o(odr), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // bench model of one write
  function automatic logic [15:0] apply(input logic [15:0] m, input logic [3:0] a,
                                        input logic [31:0] d, input logic [3:0] b);
    logic [15:0] r = m;
    logic [15:0] s, c;
    if (a == 4'd0) begin
      if (b[0]) r[7:0]  = d[7:0];
      if (b[1]) r[15:8] = d[15:8];
    end else if (a == 4'd1) begin
      s = d[15:0]  & {{8{b[1]}}, {8{b[0]}}};
      c = d[31:16] & {{8{b[3]}}, {8{b[2]}}};
      r = (r & ~c) | s;
    end
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d; be = b;
    @(negedge clk);
    we = 1'b0; wdata = '0; be = '0;
    model = apply(model, a, d, b);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 odr after reset", {16'b0, odr}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rst = 1'b0;

    // R2: full direct write, upper half ignored
    wr(4'd0, 32'hFFFF_A5C3, 4'hF);
    chk("R2 direct full", {16'b0, odr}, 32'h0000_A5C3);
    // R2: byte strobes on direct write
    wr(4'd0, 32'h0000_1234, 4'b0001);
    chk("R2 direct low byte", {16'b0, odr}, 32'h0000_A534);
    wr(4'd0, 32'h0000_7700, 4'b1110);
    chk("R2 direct high byte only", {16'b0, odr}, 32'h0000_7734);

    // R3 set, R4 clear, R5 hold
    wr(4'd0, 32'h0000_0F0F, 4'h3);
    wr(4'd1, 32'h0000_00F0, 4'hF);
    chk("R3 set bits", {16'b0, odr}, 32'h0000_0FFF);
    wr(4'd1, 32'h0F00_0000, 4'hF);
    chk("R4 clear bits", {16'b0, odr}, 32'h0000_00FF);
    wr(4'd1, 32'h0000_0000, 4'hF);
    chk("R5 zeros hold", {16'b0, odr}, 32'h0000_00FF);

    // R6: set beats clear
    wr(4'd1, 32'hFFFF_8001, 4'hF);
    chk("R6 set wins", {16'b0, odr}, 32'h0000_8001);

    // R7: strobes gate halves
    wr(4'd1, 32'hFFFF_FFFF, 4'b0100);
    chk("R7 clear low byte only", {16'b0, odr}, 32'h0000_8000);
    wr(4'd1, 32'hFFFF_FFFF, 4'b0010);
    chk("R7 set high byte only", {16'b0, odr}, 32'h0000_FF00);

    // R8: readback
    rd(4'd0, v);
    chk("R8 read direct", v, 32'h0000_FF00);
    rd(4'd1, v);
    chk("R8 read set/clear is zero", v, 32'h0);
    rd(4'd7, v);
    chk("R8 read other index zero", v, 32'h0);

    // R9: stray address and idle cycles
    wr(4'd5, 32'hFFFF_FFFF, 4'hF);
    chk("R9 stray write ignored", {16'b0, odr}, 32'h0000_FF00);
    @(negedge clk); addr = 4'd0; wdata = 32'h0000_FFFF; be = 4'hF; we = 1'b0;
    @(negedge clk);
    chk("R9 we low ignored", {16'b0, odr}, 32'h0000_FF00);
    wdata = '0; be = '0;

    // R10: direct write after set/clear
    wr(4'd1, 32'h00FF_0F0F, 4'hF);
    wr(4'd0, 32'h0000_3C3C, 4'h3);
    chk("R10 direct after set/clear", {16'b0, odr}, 32'h0000_3C3C);

    // sweep of mixed operations against the model (R2..R7, R9, R10)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a, b;
      logic [31:0] d;
      seed = nxt(seed); d = seed;
      seed = nxt(seed);
      a = (seed[2:0] < 3'd3) ? 4'd0 : (seed[2:0] < 3'd7) ? 4'd1 : seed[7:4];
      b = seed[11:8];
      wr(a, d, b);
      chk("R3 R4 R5 R6 R7 sweep odr", {16'b0, odr}, {16'b0, model});
      if (n % 16 == 0) begin
        rd(4'd0, v);
        chk("R8 sweep read", v, {16'b0, model});
      end
    end

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears odr", {16'b0, odr}, 32'h0);
    chk("R1 reset clears rdata", rdata, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule